// File: doc/BRIEF.md
# Edge Event Timestamper

This block watches four asynchronous digital lines and turns selected transitions on them into 64-bit timestamped event words. Each line is first brought into the clock domain by a two-stage synchronizer. A per-line debounce state machine then accepts a new level only after it has held for a fixed number of cycles. A transition of the accepted level counts as an event when the matching polarity enable for that line is set.

Every event is paired with a free-running 48-bit cycle counter and packed into one message word. Events from different lines in the same cycle share a single word. Words wait in a deep on-chip buffer until a downstream consumer takes them over a valid/ready stream. When the buffer is full, new words are dropped and a sticky flag records the loss.

The timebase and event capture are gated by a global `run` input. Enables, `run` and the flag clear are plain input ports.

Two state machines carry the control:
- **Debounce machine, one per line.**
  - `F_LOW` moves to `F_RISE` when the synchronized level is 1.
  - `F_RISE` returns to `F_LOW` if the level drops back before the count completes.
  - `F_RISE` moves to `F_HIGH` once the level has been seen high for the full length.
  - `F_HIGH` moves to `F_FALL` on a synchronized 0.
  - `F_FALL` returns to `F_HIGH` on a 1 before the count completes.
  - `F_FALL` moves to `F_LOW` once the level has been seen low for the full length.
  - The accepted level is 1 in `F_HIGH` and `F_FALL`.
- **Timebase machine.**
  - `T_STOPPED` moves to `T_RUNNING` when `run` is sampled high, and clears the counter on that edge.
  - `T_RUNNING` increments the counter each cycle while `run` stays high.
  - `T_RUNNING` returns to `T_STOPPED`, holding the count, when `run` is sampled low.

Top module: `evt_stamper`

## Requirements
- R1: After reset `m_valid` is 0 and `ovf` is 0.
- R2: A line's accepted level changes only after the synchronized input has shown the new level on 4 consecutive clock edges. A pulse of 3 cycles in either direction yields no message. A pulse of 4 cycles yields one message for each of its two transitions.
- R3: Suppose a raw input change is first sampled at clock edge k, the FIFO is empty, and the change survives the filter. The resulting word then appears on `m_data` with `m_valid` high after edge k+6, and not earlier.
- R4: A rising transition on line c produces a message only when `rise_en[c]` is 1. A falling transition on line c produces a message only when `fall_en[c]` is 1.
- R5: Message layout:
  - bits 63:60 hold 4'h1;
  - bits 59:56 hold a per-line flag, 1 for a rising transition and 0 for a falling one;
  - bits 55:52 hold the mask of lines that have an event in the word (bit c = line c);
  - bits 51:48 are 0;
  - bits 47:0 hold the timestamp.
- R6: Enabled transitions on several lines in the same cycle produce exactly one word, with each of those lines set in the mask.
- R7: The timestamp counter clears at the first edge where `run` is sampled high after being low, and then adds 1 per edge while `run` stays high. If `run` is first sampled high at edge r and a raw change is first sampled at edge k, the word carries k-r+5.
- R8: While `run` is low, transitions produce no message and the timestamp counter holds its value.
- R9: Words leave in the order they were captured, one per edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` does not change.
- R10: A word arriving while the FIFO holds its full depth is discarded and sets `ovf`. The words already stored are kept intact.
- R11: `ovf` stays set until an edge where `ovf_clr` is high. If a word is discarded at that same edge, `ovf` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Global enable for timebase and event capture |
| rise_en | input | 4 | Per-line rising-transition enable |
| fall_en | input | 4 | Per-line falling-transition enable |
| din | input | 4 | Asynchronous digital lines |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| m_data | output | 64 | Message word at the FIFO head |
| m_valid | output | 1 | A message word is available |
| m_ready | input | 1 | Consumer accepts the word this cycle |
| ovf | output | 1 | Sticky flag: a message was dropped |

## Verification
A raw change sampled at edge k moves through this path:
- two synchronizer stages;
- four filter samples, so the accepted level changes at edge k+5;
- one previous-level register, so the word is written at edge k+6.

The bench drives every input just after a falling edge and counts rising edges itself. It therefore knows the index of the first sampling edge and checks `m_valid` on the falling edges just before and just after k+6. The expected timestamp is k-r+5, computed from the same edge count. Overflow and flag-clear results are due on the edge that writes the dropped word, and are sampled on the falling edge that follows. Stored words are drained afterwards, one per cycle, and each is compared against the queue the bench built from the requirements.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int CH_N    = 4;
    localparam int TS_W    = 48;
    localparam int MSG_W   = 64;
    localparam logic [3:0] MSG_TYPE_EVENT = 4'h1;

    typedef enum logic [1:0] {
        F_LOW,
        F_RISE,
        F_HIGH,
        F_FALL
    } filt_state_t;

    typedef enum logic {
        T_STOPPED,
        T_RUNNING
    } tbase_state_t;

    function automatic logic [MSG_W-1:0] pack_event(
        input logic [CH_N-1:0] rise_flags,
        input logic [CH_N-1:0] line_mask,
        input logic [TS_W-1:0] stamp
    );
        return {MSG_TYPE_EVENT, rise_flags, line_mask, 4'h0, stamp};
    endfunction

endpackage

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter
    import evt_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din_async,
    output logic lvl
);

    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic        sync_a, sync_b;
    filt_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // two-stage synchronizer
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= din_async;
            sync_b <= sync_a;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= F_LOW;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            F_LOW: begin
                if (sync_b) begin
                    st_d  = F_RISE;
                    cnt_d = CW'(1);
                end
            end
            F_RISE: begin
                if (!sync_b) begin
                    st_d  = F_LOW;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    st_d  = F_HIGH;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            F_HIGH: begin
                if (!sync_b) begin
                    st_d  = F_FALL;
                    cnt_d = CW'(1);
                end
            end
            F_FALL: begin
                if (sync_b) begin
                    st_d  = F_HIGH;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    st_d  = F_LOW;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            F_LOW, F_RISE:  lvl = 1'b0;
            F_HIGH, F_FALL: lvl = 1'b1;
        endcase
    end

endmodule

// File: rtl/evt_msg_builder.sv
module evt_msg_builder
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CH_N-1:0]  rise_en,
    input  logic [CH_N-1:0]  fall_en,
    input  logic [CH_N-1:0]  lvl,
    output logic             wr_en,
    output logic [MSG_W-1:0] wr_data,
    output logic [TS_W-1:0]  ts_now,
    output logic             ts_running
);

    tbase_state_t    tb_q, tb_d;
    logic [TS_W-1:0] ts_q, ts_d;
    logic [CH_N-1:0] lvl_q;
    logic [CH_N-1:0] rise_hit, fall_hit, any_hit;

    // timebase state register
    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= T_STOPPED;
            ts_q <= '0;
        end else begin
            tb_q <= tb_d;
            ts_q <= ts_d;
        end
    end

    always_comb begin
        tb_d = tb_q;
        ts_d = ts_q;
        unique case (tb_q)
            T_STOPPED: begin
                if (run) begin
                    tb_d = T_RUNNING;
                    ts_d = '0;
                end
            end
            T_RUNNING: begin
                if (run) ts_d = ts_q + TS_W'(1);
                else     tb_d = T_STOPPED;
            end
        endcase
    end

    // previous accepted levels for transition detection
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    // outputs
    always_comb begin
        rise_hit   = lvl & ~lvl_q & rise_en;
        fall_hit   = ~lvl & lvl_q & fall_en;
        any_hit    = rise_hit | fall_hit;
        wr_en      = run && (any_hit != '0);
        wr_data    = pack_event(rise_hit, any_hit, ts_q);
        ts_now     = ts_q;
        ts_running = (tb_q == T_RUNNING);
    end

endmodule

// File: rtl/evt_msg_fifo.sv
module evt_msg_fifo #(
    parameter int DW = 64,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop_rdy,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          full,
    input  logic          ovf_clr,
    output logic          ovf
);

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   fill;
    logic          do_push, do_pop, drop;

    always_comb begin
        full      = (fill == CNT_FULL);
        out_valid = (fill != '0);
        out_data  = mem[rd_ptr];
        do_push   = push && !full;
        drop      = push && full;
        do_pop    = out_valid && pop_rdy;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + (AW+1)'(1);
                2'b01:   fill <= fill - (AW+1)'(1);
                default: fill <= fill;
            endcase
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_stamper.sv
module evt_stamper
    import evt_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int FIFO_AW  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic [3:0]  rise_en,
    input  logic [3:0]  fall_en,
    input  logic [3:0]  din,
    input  logic        ovf_clr,
    output logic [63:0] m_data,
    output logic        m_valid,
    input  logic        m_ready,
    output logic        ovf
);

    logic [CH_N-1:0]  lvl_vec;
    logic             evt_push;
    logic [MSG_W-1:0] evt_word;
    logic [TS_W-1:0]  ts_now;
    logic             ts_running;
    logic             fifo_full;

    for (genvar c = 0; c < CH_N; c++) begin : g_line
        evt_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk       (clk),
            .rst       (rst),
            .din_async (din[c]),
            .lvl       (lvl_vec[c])
        );
    end

    evt_msg_builder u_build (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .lvl        (lvl_vec),
        .wr_en      (evt_push),
        .wr_data    (evt_word),
        .ts_now     (ts_now),
        .ts_running (ts_running)
    );

    evt_msg_fifo #(.DW(MSG_W), .AW(FIFO_AW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (evt_push),
        .push_data (evt_word),
        .pop_rdy   (m_ready),
        .out_data  (m_data),
        .out_valid (m_valid),
        .full      (fifo_full),
        .ovf_clr   (ovf_clr),
        .ovf       (ovf)
    );

endmodule

// File: rtl/evt_stamper_chk.sv
module evt_stamper_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic [63:0] m_data,
    input logic        m_valid,
    input logic        m_ready,
    input logic        ovf,
    input logic        ovf_clr,
    input logic        fifo_full,
    input logic        evt_push,
    input logic [47:0] ts_now,
    input logic        ts_running
);

    // R9: stalled head word is held
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R5: layout of every word presented
    p_msg_format_r5: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_data[63:60] == 4'h1 && m_data[51:48] == 4'h0 &&
                     m_data[55:52] != 4'h0 &&
                     (m_data[59:56] & ~m_data[55:52]) == 4'h0));

    // R7: counter steps by one while running
    p_ts_step_r7: assert property (@(posedge clk) disable iff (rst)
        (ts_running && run) |=> (ts_now == $past(ts_now) + 48'd1));

    // R8: counter holds while run is low
    p_ts_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(ts_now));

    // R10: flag only rises after a push into a full buffer
    p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(fifo_full && evt_push));

    // R11: clear takes effect when no drop coincides
    p_ovf_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(evt_push && fifo_full)) |=> !ovf);

endmodule

bind evt_stamper evt_stamper_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .m_data     (m_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .ovf        (ovf),
    .ovf_clr    (ovf_clr),
    .fifo_full  (fifo_full),
    .evt_push   (evt_push),
    .ts_now     (ts_now),
    .ts_running (ts_running)
);

// File: tb/evt_stamper_bench.sv
module evt_stamper_bench;

    localparam time CLK_PERIOD = 8;
    localparam int  AW_T = 3;
    localparam int  DEPTH_T = 1 << AW_T;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [3:0]  rise_en, fall_en, din;
    logic        ovf_clr;
    logic [63:0] m_data;
    logic        m_valid;
    logic        m_ready;
    logic        ovf;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int t_run  = 0;
    logic [63:0] expq [$];

    evt_stamper #(.FILT_LEN(4), .FIFO_AW(AW_T)) u_evt_stamper (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .din     (din),
        .ovf_clr (ovf_clr),
        .m_data  (m_data),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .ovf     (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic logic [63:0] mk(input logic [3:0] flags,
                                       input logic [3:0] mask, input int b);
        return {4'h1, flags, mask, 4'h0, 48'(b - t_run + 5)};
    endfunction

    task automatic drain(input string req);
        while (expq.size() > 0) begin
            logic [63:0] e;
            e = expq.pop_front();
            check(m_valid === 1'b1 && m_data === e, req, m_data, e);
            m_ready = 1'b1;
            @(negedge clk);
            m_ready = 1'b0;
        end
        check(m_valid === 1'b0, req, {63'd0, m_valid}, 64'd0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int b, b2;
        rst = 1'b1; run = 1'b0; rise_en = '0; fall_en = '0; din = '0;
        ovf_clr = 1'b0; m_ready = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(m_valid === 1'b0, "R1 valid", {63'd0, m_valid}, 64'd0);
        check(ovf === 1'b0, "R1 ovf", {63'd0, ovf}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        run = 1'b1; t_run = cyc;
        rise_en = 4'hF; fall_en = 4'hF;
        wait_to(cyc + 3);

        // R3: latency of an accepted transition
        b = cyc; din = 4'b0001;
        expq.push_back(mk(4'b0001, 4'b0001, b));
        wait_to(b + 6);
        check(m_valid === 1'b0, "R3 early", {63'd0, m_valid}, 64'd0);
        wait_to(b + 7);
        check(m_valid === 1'b1, "R3 due", {63'd0, m_valid}, 64'd1);
        wait_to(b + 10);
        b2 = cyc; din = 4'b0000;
        expq.push_back(mk(4'b0000, 4'b0001, b2));
        wait_to(b2 + 8);
        drain("R3");

        // R2: three-cycle high pulse is rejected
        b = cyc; din = 4'b0010;
        wait_to(b + 3); din = 4'b0000;
        wait_to(b + 14);
        check(m_valid === 1'b0, "R2 short pulse", {63'd0, m_valid}, 64'd0);
        // R2: four-cycle pulse yields two words
        b = cyc; din = 4'b0010;
        expq.push_back(mk(4'b0010, 4'b0010, b));
        wait_to(b + 4); din = 4'b0000;
        expq.push_back(mk(4'b0000, 4'b0010, b + 4));
        wait_to(b + 14);
        drain("R2 four-cycle");
        // R2: three-cycle low dip from high is rejected
        b = cyc; din = 4'b0100;
        expq.push_back(mk(4'b0100, 4'b0100, b));
        wait_to(b + 8);
        b = cyc; din = 4'b0000;
        wait_to(b + 3); din = 4'b0100;
        wait_to(b + 14);
        drain("R2 low dip");
        b = cyc; din = 4'b0000;
        expq.push_back(mk(4'b0000, 4'b0100, b));
        wait_to(b + 8);
        drain("R2 release");

        // R4 R5 R6: sweep line masks and enable patterns
        for (int mask = 1; mask < 16; mask++) begin
            for (int re = 0; re < 16; re++) begin
                logic [3:0] rm, fm;
                rise_en = 4'(re);
                fall_en = 4'(re) ^ 4'b0101;
                rm = 4'(mask) & rise_en;
                fm = 4'(mask) & fall_en;
                b = cyc; din = 4'(mask);
                if (rm != 0) expq.push_back(mk(rm, rm, b));
                wait_to(b + 8);
                b2 = cyc; din = 4'b0000;
                if (fm != 0) expq.push_back(mk(4'b0000, fm, b2));
                wait_to(b2 + 8);
                drain("R4 R5 R6 sweep");
            end
        end

        // R8: no words while run is low
        rise_en = 4'hF; fall_en = 4'hF;
        run = 1'b0;
        wait_to(cyc + 2);
        b = cyc; din = 4'hF;
        wait_to(b + 8); din = 4'h0;
        wait_to(b + 16);
        check(m_valid === 1'b0, "R8 stopped", {63'd0, m_valid}, 64'd0);
        // R7: restart clears the counter
        run = 1'b1; t_run = cyc;
        wait_to(cyc + 2);
        b = cyc; din = 4'b1000;
        expq.push_back(mk(4'b1000, 4'b1000, b));
        wait_to(b + 8);
        b2 = cyc; din = 4'b0000;
        expq.push_back(mk(4'b0000, 4'b1000, b2));
        wait_to(b2 + 8);
        drain("R7 restart");

        // R10 R11: fill, overflow, clear; R9 ordering on drain
        rise_en = 4'b0001; fall_en = 4'b0001;
        for (int i = 0; i < DEPTH_T + 2; i++) begin
            b = cyc; din[0] = ~din[0];
            if (i < DEPTH_T) expq.push_back(mk({3'b000, din[0]}, 4'b0001, b));
            if (i == DEPTH_T + 1) begin
                wait_to(b + 6); ovf_clr = 1'b1;
                wait_to(b + 7); ovf_clr = 1'b0;
                check(ovf === 1'b1, "R11 set wins", {63'd0, ovf}, 64'd1);
            end else begin
                wait_to(b + 7);
                if (i == DEPTH_T - 1)
                    check(ovf === 1'b0, "R10 full no drop", {63'd0, ovf}, 64'd0);
                if (i == DEPTH_T)
                    check(ovf === 1'b1, "R10 drop", {63'd0, ovf}, 64'd1);
            end
            wait_to(b + 8);
        end
        drain("R10 R9 stored order");
        check(ovf === 1'b1, "R11 sticky", {63'd0, ovf}, 64'd1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf === 1'b0, "R11 clear", {63'd0, ovf}, 64'd0);

        finish_run();
    end

endmodule